// File: doc/BRIEF.md
# Single-Pointer Survivor Memory Sequencer

This block holds the survivor decisions of a 64-state Viterbi decoder and turns them into a stream of decoded bits. The add-compare-select stage hands it one 64-bit decision word per trellis step, one bit per state. The block files each word into whichever of four rotating banks is currently being filled. Every bank is `DEPTH` columns deep.

A single read pointer does all of the reading. It makes three read steps for each accepted decision word, so within one bank period it can walk three full banks. It first traces back through the newest complete bank, then through the bank before that, and then decodes the oldest bank. The state reached at the end of the two trace-back passes becomes the starting state of the decode pass.

The decoded bits come out in reverse time order. They are pushed into a last-in-first-out stack, and once the decode pass ends they are sent out in forward order as a run of `DEPTH` consecutive valid cycles. Decision words must be at least three clock cycles apart. Gaps longer than that only pause the read engine and do not change its result.

Top module: `survivor_traceback`

## Requirements
- R1: While reset is held, and after it is released, `bitValid` is low until decoding has been armed.
- R2: An accepted word (`decValid` high) is stored at the current write column of the current write bank, where bit i belongs to state i. The column advances by one per accepted word. After `DEPTH` words the write moves to the next bank, counting modulo four.
- R3: Each accepted word causes exactly three read steps, in the three cycles that follow it. A bank period therefore consists of three read passes of `DEPTH` steps each. The first pass covers the newest full bank, the second covers the bank before it, and the third (the decode pass) covers the bank three behind the write bank. Each pass reads from column `DEPTH-1` down to column 0.
- R4: At each read step with current state s and decision bit d = word[s], the next state is {d, s[5:1]}. This follows the trellis convention that the next state is {s[4:0], input}.
- R5: The seed state is sampled only together with the word written to column 0 of a bank. If `seedValid` is high at that moment, the first trace-back pass starts from `seedState`; otherwise it starts from state 0. Seed inputs presented with any other column are ignored.
- R6: In the decode pass, the bit decoded for a column is the LSB of the current state before that column's step is applied.
- R7: When a decode pass ends, its `DEPTH` bits appear on `bitOut` in the following `DEPTH` cycles, with `bitValid` high throughout. Column 0, the oldest step, comes out first.
- R8: The first three bank periods produce no output. The first decode that is emitted covers bank 0, and it is emitted during the fourth period.
- R9: From then on, every bank is decoded and emitted exactly once and in order, with no bits lost or repeated.
- R10: Idle gaps longer than three cycles between accepted words do not change any decoded value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| decWord | input | 64 | Survivor decision bits, one per state |
| decValid | input | 1 | Strobe for decWord, at most once every three cycles |
| seedState | input | 6 | Trace-back starting state offered with column 0 |
| seedValid | input | 1 | seedState is meaningful |
| bitOut | output | 1 | Decoded bit, oldest first |
| bitValid | output | 1 | bitOut is valid |

## Verification
The bench keeps its own copy of every decision word and traces each bank period in software. The corner cases it targets are these:
- Periods seeded with `seedValid` low. A design that ignored the zero default, or that took a stale seed, would decode a different path.
- Seed inputs toggled on columns other than 0. A design that sampled them there would start from the wrong state.
- Irregular gaps between words. A free-running read pointer would drift out of step with the bank rotation.
- The end of the pipeline fill. Any output before the fourth period, or a missing or doubled bank of bits at a rotation, shows up directly as a surplus, a shortfall or a mismatch against the scoreboard queue.

// File: rtl/survivor_pkg.sv
package survivor_pkg;
  localparam int NUM_STATES      = 64;
  localparam int STATE_W         = 6;
  localparam int NUM_BANKS       = 4;
  localparam int BANK_W          = 2;
  localparam int READS_PER_WRITE = 3;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic wrEn;        // store decWord this cycle
    logic wrFirst;     // store is to column 0 of a bank
    logic stepEn;      // one read step this cycle
    logic tbStart;     // first step of a bank period
    logic decodeEn;    // step belongs to the decode pass
    logic decodeLast;  // final step of the decode pass
    logic armed;       // pipeline filled, decode results are real
  } seqCtl_t;
endpackage

// File: rtl/survivor_ctrl.sv
module survivor_ctrl
  import survivor_pkg::*;
#(
  parameter int DEPTH = 32,
  localparam int COL_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              decValid,
  output seqCtl_t           ctl,
  output logic [BANK_W-1:0] wrBank,
  output logic [COL_W-1:0]  wrCol,
  output logic [BANK_W-1:0] rdBank,
  output logic [COL_W-1:0]  rdCol
);
  localparam logic [COL_W-1:0] LAST_COL = COL_W'(DEPTH - 1);

  logic [1:0]        pendSteps;
  logic [1:0]        rdPhase;    // 0: newest bank, 1: older bank, 2: decode
  logic [BANK_W-1:0] rdPeriod;   // bank written during this read period
  logic [1:0]        fillCount;  // completed read periods, saturating at 3
  logic [2:0]        pendNext;

  always_comb begin
    ctl.wrEn       = decValid;
    ctl.wrFirst    = decValid && (wrCol == '0);
    ctl.stepEn     = (pendSteps != 2'd0);
    ctl.tbStart    = ctl.stepEn && (rdPhase == 2'd0) && (rdCol == LAST_COL);
    ctl.decodeEn   = ctl.stepEn && (rdPhase == 2'd2);
    ctl.decodeLast = ctl.decodeEn && (rdCol == '0);
    ctl.armed      = (fillCount == 2'd3);
    rdBank         = rdPeriod - BANK_W'(1) - BANK_W'(rdPhase);
    pendNext       = {1'b0, pendSteps} - {2'b00, ctl.stepEn}
                   + (decValid ? 3'(READS_PER_WRITE) : 3'd0);
  end

  // write side column and bank counters
  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrCol  <= '0;
      wrBank <= '0;
    end else if (decValid) begin
      if (wrCol == LAST_COL) begin
        wrCol  <= '0;
        wrBank <= wrBank + BANK_W'(1);
      end else begin
        wrCol <= wrCol + COL_W'(1);
      end
    end
  end

  // read side: three steps owed per accepted word
  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendSteps <= '0;
    end else begin
      pendSteps <= pendNext[1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdCol     <= LAST_COL;
      rdPhase   <= '0;
      rdPeriod  <= '0;
      fillCount <= '0;
    end else if (ctl.stepEn) begin
      if (rdCol == '0) begin
        rdCol <= LAST_COL;
        if (rdPhase == 2'd2) begin
          rdPhase  <= '0;
          rdPeriod <= rdPeriod + BANK_W'(1);
          if (fillCount != 2'd3) fillCount <= fillCount + 2'd1;
        end else begin
          rdPhase <= rdPhase + 2'd1;
        end
      end else begin
        rdCol <= rdCol - COL_W'(1);
      end
    end
  end
endmodule

// File: rtl/survivor_path.sv
module survivor_path
  import survivor_pkg::*;
#(
  parameter int DEPTH = 32,
  localparam int COL_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  seqCtl_t               ctl,
  input  logic [NUM_STATES-1:0] decWord,
  input  logic [STATE_W-1:0]    seedState,
  input  logic                  seedValid,
  input  logic [BANK_W-1:0]     wrBank,
  input  logic [COL_W-1:0]      wrCol,
  input  logic [BANK_W-1:0]     rdBank,
  input  logic [COL_W-1:0]      rdCol,
  output logic [STATE_W-1:0]    traceState,
  output logic                  traceBit,
  output logic                  bitOut,
  output logic                  bitValid
);
  logic [NUM_STATES-1:0] bankRd [NUM_BANKS];
  logic [NUM_STATES-1:0] rdWord;
  logic [STATE_W-1:0]    seedLatch;
  logic [STATE_W-1:0]    stateReg;
  logic [DEPTH-1:0]      lifo;
  logic [DEPTH-1:0]      outBuf;
  logic [CNT_W-1:0]      outLeft;

  // one storage array per bank
  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic [NUM_STATES-1:0] store [DEPTH];
    always_ff @(posedge clk) begin
      if (ctl.wrEn && (wrBank == BANK_W'(b))) store[wrCol] <= decWord;
    end
    assign bankRd[b] = store[rdCol];
  end

  assign rdWord     = bankRd[rdBank];
  assign traceState = ctl.tbStart ? seedLatch : stateReg;
  assign traceBit   = rdWord[traceState];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      seedLatch <= '0;
    end else if (ctl.wrFirst) begin
      seedLatch <= seedValid ? seedState : '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateReg <= '0;
    end else if (ctl.stepEn) begin
      stateReg <= {traceBit, traceState[STATE_W-1:1]};
    end
  end

  // reorder stack: pushed newest-first, popped oldest-first
  always_ff @(posedge clk) begin
    if (!rstN) begin
      lifo <= '0;
    end else if (ctl.decodeEn) begin
      lifo <= {lifo[DEPTH-2:0], traceState[0]};
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outBuf  <= '0;
      outLeft <= '0;
    end else if (ctl.decodeLast && ctl.armed) begin
      outBuf  <= {lifo[DEPTH-2:0], traceState[0]};
      outLeft <= CNT_W'(DEPTH);
    end else if (outLeft != '0) begin
      outBuf  <= {1'b0, outBuf[DEPTH-1:1]};
      outLeft <= outLeft - CNT_W'(1);
    end
  end

  assign bitOut   = outBuf[0];
  assign bitValid = (outLeft != '0);
endmodule

// File: rtl/survivor_traceback.sv
module survivor_traceback
  import survivor_pkg::*;
#(
  parameter int DEPTH = 32
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [63:0] decWord,
  input  logic        decValid,
  input  logic [5:0]  seedState,
  input  logic        seedValid,
  output logic        bitOut,
  output logic        bitValid
);
  localparam int COL_W = $clog2(DEPTH);

  seqCtl_t           ctl;
  logic [BANK_W-1:0] wrBank;
  logic [COL_W-1:0]  wrCol;
  logic [BANK_W-1:0] rdBank;
  logic [COL_W-1:0]  rdCol;
  logic [5:0]        traceState;
  logic              traceBit;

  survivor_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rstN(rstN), .decValid(decValid), .ctl(ctl),
    .wrBank(wrBank), .wrCol(wrCol), .rdBank(rdBank), .rdCol(rdCol)
  );

  survivor_path #(.DEPTH(DEPTH)) u_path (
    .clk(clk), .rstN(rstN), .ctl(ctl), .decWord(decWord),
    .seedState(seedState), .seedValid(seedValid),
    .wrBank(wrBank), .wrCol(wrCol), .rdBank(rdBank), .rdCol(rdCol),
    .traceState(traceState), .traceBit(traceBit),
    .bitOut(bitOut), .bitValid(bitValid)
  );
endmodule

// File: rtl/survivor_checker.sv
module survivor_checker
  import survivor_pkg::*;
#(
  parameter int DEPTH = 32,
  localparam int COL_W = $clog2(DEPTH)
) (
  input logic             clk,
  input logic             rstN,
  input logic             decValid,
  input logic             bitValid,
  input seqCtl_t          ctl,
  input logic [COL_W-1:0] rdCol,
  input logic [5:0]       traceState,
  input logic             traceBit
);
  // R10: words arrive no closer than three cycles apart
  p_word_spacing_r10: assert property (@(posedge clk) disable iff (!rstN)
    decValid |-> ##1 !decValid ##1 !decValid);

  // R3: a pass that reaches column 0 restarts at the top column
  p_col_wrap_r3: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.stepEn && rdCol == '0) |=> (rdCol == COL_W'(DEPTH - 1)));

  // R4: consecutive steps follow the shift rule
  p_trace_rule_r4: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.stepEn && $past(ctl.stepEn) && !ctl.tbStart)
      |-> (traceState == {$past(traceBit), $past(traceState[5:1])}));

  // R8: nothing leaves before the pipeline is armed
  p_quiet_until_armed_r8: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.armed |-> !bitValid);

  // R7: an armed decode end starts an output run
  p_run_start_r7: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.decodeLast && ctl.armed) |=> bitValid);
endmodule

bind survivor_traceback survivor_checker #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rstN(rstN), .decValid(decValid), .bitValid(bitValid),
  .ctl(ctl), .rdCol(rdCol), .traceState(traceState), .traceBit(traceBit)
);

// File: tb/tb_survivor_traceback.sv
module tb_survivor_traceback;
  localparam int D    = 32;
  localparam int NPER = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [63:0] decWord = '0;
  logic        decValid = 1'b0;
  logic [5:0]  seedState = '0;
  logic        seedValid = 1'b0;
  logic        bitOut;
  logic        bitValid;

  int checks = 0;
  int fails  = 0;
  bit expectLive = 1'b0;

  logic [63:0] dec [NPER*D];
  bit          expQ[$];

  always #2.5 clk = ~clk;

  survivor_traceback #(.DEPTH(D)) dut (
    .clk(clk), .rstN(rstN), .decWord(decWord), .decValid(decValid),
    .seedState(seedState), .seedValid(seedValid),
    .bitOut(bitOut), .bitValid(bitValid)
  );

  // reference trace for bank period n: R3 R4 R5 R6
  task automatic pushExpected(input int n, input logic [5:0] start);
    logic [5:0] s;
    bit bits [D];
    s = start;
    for (int t = n*D - 1; t >= (n-2)*D; t--) s = {dec[t][s], s[5:1]};
    for (int t = (n-2)*D - 1; t >= (n-3)*D; t--) begin
      bits[t - (n-3)*D] = s[0];
      s = {dec[t][s], s[5:1]};
    end
    for (int i = 0; i < D; i++) expQ.push_back(bits[i]);
  endtask

  // monitor: compares each emitted bit against the queue
  always @(negedge clk) begin
    if (rstN && bitValid) begin
      checks++;
      if (expQ.size() == 0) begin
        fails++;
        $display("FAIL R8 R9: output bit %0d with nothing expected", bitOut);
      end else begin
        bit e;
        e = expQ.pop_front();
        if (bitOut !== e) begin
          fails++;
          $display("FAIL R2 R3 R4 R5 R6 R7 R9 R10: got %0d expected %0d", bitOut, e);
        end
      end
    end
  end

  initial begin
    logic [5:0] pathS;
    logic [5:0] seeds [NPER];
    bit         seedOn [NPER];
    pathS = '0;
    for (int n = 0; n < NPER; n++) begin
      seedOn[n] = !(n == 3 || n == 6);   // R5 zero default on two periods
      for (int c = 0; c < D; c++) begin
        int t;
        logic u;
        t = n*D + c;
        dec[t] = {$urandom, $urandom};
        if (n >= 5) begin
          // path-consistent words for the later periods
          u = 1'($urandom);
          dec[t][{pathS[4:0], u}] = pathS[5];
          pathS = {pathS[4:0], u};
        end
      end
      seeds[n] = (n >= 5) ? pathS : 6'($urandom);
    end

    repeat (4) @(negedge clk);
    checks++;
    if (bitValid !== 1'b0) begin
      fails++;
      $display("FAIL R1: bitValid %0d during reset expected 0", bitValid);
    end
    rstN = 1'b1;
    @(negedge clk);
    checks++;
    if (bitValid !== 1'b0) begin
      fails++;
      $display("FAIL R1: bitValid %0d after reset expected 0", bitValid);
    end

    for (int n = 0; n < NPER; n++) begin
      // seed offered with column 0 is the state at the end of bank n-1
      if (n >= 3) pushExpected(n, seedOn[n] ? seeds[n-1] : 6'd0);
      for (int c = 0; c < D; c++) begin
        int gap;
        gap = (n % 2 == 0) ? 3 : 3 + int'($urandom_range(0, 3)); // R10
        decWord  = dec[n*D + c];
        decValid = 1'b1;
        if (c == 0) begin
          seedValid = seedOn[n];
          seedState = seeds[(n == 0) ? 0 : n-1];
        end else begin
          // R5: junk seeds on other columns must be ignored
          seedValid = 1'b1;
          seedState = 6'($urandom);
        end
        @(negedge clk);
        decValid  = 1'b0;
        seedValid = 1'b0;
        repeat (gap - 1) @(negedge clk);
      end
    end

    repeat (3*D + 20) @(negedge clk);
    checks++;
    if (expQ.size() != 0) begin
      fails++;
      $display("FAIL R9: %0d expected bits never emitted, expected 0", expQ.size());
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL R9: watchdog expired, got hang expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule